// File: doc/BRIEF.md
# Seven-Level Staircase Gate Pattern Generator

This block turns a signed sine reference sample into the seven switch-gate bits of a single-phase seven-level inverter by unipolar level-shifted PWM. A digital triangle carrier runs between zero and a programmable peak. Three stacked copies of it (offset by zero, one and two peaks) are compared against the magnitude of the reference, giving three band bits. A fourth bit records whether the reference is non-negative. A fixed set of sum-of-products equations maps these four bits onto the gates, so the bridge output steps through 0, ±E, ±2E and ±3E.

The carrier peak sets the PWM period, which is two peaks long. It also sets the depth of modulation: the modulation index is the rectified reference peak divided by three carrier peaks. The block also reports a signed level index, the band count with the reference sign, for monitoring. Both the band bits and the gate outputs are registered, so the gates never glitch.

Top module: `mlpwm_gate_top`

## Requirements
- R1: While reset (active-low, synchronous) is asserted, all seven gate bits and the level index are 0 and the carrier is cleared to 0 with its ramp direction set to up.
- R2: With a nonzero carrier peak P, the carrier takes one value per clock in the order 0,1,...,P,P-1,...,1,0,1,... and this repeats with a period of 2P clocks.
- R3: With carrier value t and reference magnitude m, bit A is m >= t, bit B is m >= t+P and bit C is m >= t+2P, so a magnitude equal to a carrier counts as above it. The sign bit D is 1 when the reference is zero or positive.
- R4: With bits A,B,C,D, the gate vector is [0]=B·C'·D + A·B'·D', [1]=D·(B+C), [2]=A·B'·D + B·C'·D', [3]=A' + D·(C+B'), [4]=B·C' + D·(A+C), [5]=A' + A·B'·D' + C·D', [6]=D'·(B+C). This yields, per level index, the patterns 0x28 for 0, 0x1C for +1, 0x13 for +2, 0x1A for +3, 0x21 for -1, 0x54 for -2 and 0x60 for -3.
- R5: The level index is a 3-bit two's complement value equal to A+B+C when D is 1 and to -(A+B+C) when D is 0; it never takes the value -4.
- R6: A reference sample present at clock edge k, together with the carrier value held just before that edge, sets the gate and level outputs that appear after edge k+1 (two-register latency).
- R7: A carrier peak of 0 holds the carrier at 0, so every band counts as passed and the level index is +3 or -3 depending on the sign.
- R8: Full-scale references, including the most negative code, produce correct magnitudes, and a magnitude beyond the upper band gives level ±3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| refSample | input | REF_W | Signed reference sample |
| carrierPeak | input | CAR_W | Carrier peak P (half the PWM period in clocks) |
| gates | output | 7 | Gate bits, positions as in R4 |
| level | output | 3 | Signed output level index |

## Verification
The carrier turning round at its peak or at zero can coincide with a reference magnitude that sits exactly on a band edge. In that cycle the direction change and the equality rule both decide one band bit. A slow reference sweep with a small peak makes these meetings frequent. Each one is judged by the scoreboard against a carrier model kept in the bench, so an off-by-one turnaround or a strict comparison shows up as a wrong level and a wrong gate pattern two clocks later.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

  // Strobes from the ramp control to the datapath carrier register
  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic clear;
  } carrierCmd_t;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } rampDir_t;

endpackage

// File: rtl/mlpwm_ramp_ctrl.sv
module mlpwm_ramp_ctrl
  import mlpwm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        atTop,
  input  logic        atBottom,
  input  logic        peakZero,
  output carrierCmd_t cmd
);

  rampDir_t dirQ;
  rampDir_t dirD;

  always_comb begin
    cmd  = '0;
    dirD = dirQ;
    if (peakZero) begin
      cmd.clear = 1'b1;
      dirD      = DIR_UP;
    end else if (dirQ == DIR_UP) begin
      if (atTop) begin
        cmd.stepDown = 1'b1;
        dirD         = DIR_DOWN;
      end else begin
        cmd.stepUp = 1'b1;
      end
    end else begin
      if (atBottom) begin
        cmd.stepUp = 1'b1;
        dirD       = DIR_UP;
      end else begin
        cmd.stepDown = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) dirQ <= DIR_UP;
    else       dirQ <= dirD;
  end

endmodule

// File: rtl/mlpwm_datapath.sv
module mlpwm_datapath
  import mlpwm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CAR_W = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [REF_W-1:0] refSample,
  input  logic        [CAR_W-1:0] carrierPeak,
  input  carrierCmd_t             cmd,
  output logic                    atTop,
  output logic                    atBottom,
  output logic                    peakZero,
  output logic        [CAR_W-1:0] carrierNow,
  output logic        [6:0]       gates,
  output logic signed [2:0]       level
);

  localparam int BAND_W = CAR_W + 2;
  localparam int CMP_W  = (REF_W > BAND_W) ? REF_W : BAND_W;
  localparam int NBANDS = 3;

  logic [CAR_W-1:0] triQ;
  logic [REF_W-1:0] magRaw;
  logic [CMP_W-1:0] magW;
  logic [CMP_W-1:0] bandEdge [NBANDS];
  logic [NBANDS-1:0] passD;
  logic [NBANDS-1:0] passQ;   // {C,B,A}
  logic              posQ;    // D

  // Carrier register
  always_ff @(posedge clk) begin
    if (!rstN)             triQ <= '0;
    else if (cmd.clear)    triQ <= '0;
    else if (cmd.stepUp)   triQ <= triQ + 1'b1;
    else if (cmd.stepDown) triQ <= triQ - 1'b1;
  end

  assign atTop      = (triQ >= carrierPeak);
  assign atBottom   = (triQ == '0);
  assign peakZero   = (carrierPeak == '0);
  assign carrierNow = triQ;

  // Rectified reference
  assign magRaw = refSample[REF_W-1] ? (~refSample + 1'b1) : refSample;
  assign magW   = CMP_W'(magRaw);

  // Stacked carriers and band comparisons
  genvar gi;
  generate
    for (gi = 0; gi < NBANDS; gi++) begin : g_band
      if (gi == 0) begin : g_base
        assign bandEdge[gi] = CMP_W'(triQ);
      end else begin : g_stack
        assign bandEdge[gi] = bandEdge[gi-1] + CMP_W'(carrierPeak);
      end
      assign passD[gi] = (magW >= bandEdge[gi]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      passQ <= '0;
      posQ  <= 1'b0;
    end else begin
      passQ <= passD;
      posQ  <= ~refSample[REF_W-1];
    end
  end

  // Gate equations over the registered bits
  logic bA, bB, bC, bD;
  logic [6:0] gateD;
  logic [1:0] bandCount;
  logic signed [2:0] levelD;

  assign bA = passQ[0];
  assign bB = passQ[1];
  assign bC = passQ[2];
  assign bD = posQ;

  always_comb begin
    gateD[0] = (bB & ~bC & bD) | (bA & ~bB & ~bD);
    gateD[1] = bD & (bC | bB);
    gateD[2] = (bA & ~bB & bD) | (bB & ~bC & ~bD);
    gateD[3] = ~bA | (bD & (bC | ~bB));
    gateD[4] = (bB & ~bC) | (bD & (bA | bC));
    gateD[5] = ~bA | (bA & ~bB & ~bD) | (bC & ~bD);
    gateD[6] = ~bD & (bB | bC);
    bandCount = {1'b0, bA} + {1'b0, bB} + {1'b0, bC};
    levelD    = bD ? $signed({1'b0, bandCount}) : -$signed({1'b0, bandCount});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gates <= '0;
      level <= '0;
    end else begin
      gates <= gateD;
      level <= levelD;
    end
  end

endmodule

// File: rtl/mlpwm_gate_top.sv
module mlpwm_gate_top
  import mlpwm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CAR_W = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [REF_W-1:0] refSample,
  input  logic        [CAR_W-1:0] carrierPeak,
  output logic        [6:0]       gates,
  output logic signed [2:0]       level
);

  carrierCmd_t      cmd;
  logic             atTop;
  logic             atBottom;
  logic             peakZero;
  logic [CAR_W-1:0] carrierNow;

  mlpwm_ramp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .atTop    (atTop),
    .atBottom (atBottom),
    .peakZero (peakZero),
    .cmd      (cmd)
  );

  mlpwm_datapath #(.REF_W(REF_W), .CAR_W(CAR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .refSample   (refSample),
    .carrierPeak (carrierPeak),
    .cmd         (cmd),
    .atTop       (atTop),
    .atBottom    (atBottom),
    .peakZero    (peakZero),
    .carrierNow  (carrierNow),
    .gates       (gates),
    .level       (level)
  );

endmodule

// File: rtl/mlpwm_gate_chk.sv
module mlpwm_gate_chk #(
  parameter int REF_W = 12,
  parameter int CAR_W = 10
) (
  input logic                    clk,
  input logic                    rstN,
  input logic signed [REF_W-1:0] refSample,
  input logic        [CAR_W-1:0] carrierPeak,
  input logic        [CAR_W-1:0] carrierNow,
  input logic        [6:0]       gates,
  input logic signed [2:0]       level
);

  // R2: carrier moves by exactly one per clock while the peak is steady and nonzero
  a_r2_carrier_step: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && carrierPeak != '0 && $stable(carrierPeak)) |->
      ((carrierNow == $past(carrierNow) + CAR_W'(1)) ||
       ($past(carrierNow) == carrierNow + CAR_W'(1))));

  // R4: every active pattern drives two or three gates
  a_r4_gate_count: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ($countones(gates) == 2 || $countones(gates) == 3));

  // R4: the zero level always uses the same freewheel pattern
  a_r4_zero_pattern: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && level == 3'sd0) |-> (gates == 7'h28));

  // R5: the level index never reaches -4
  a_r5_level_range: assert property (@(posedge clk) disable iff (!rstN)
    level != 3'b100);

  // R3 / R6: level sign follows the reference sign two clocks earlier
  a_r6_sign_latency: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 2) && $past(rstN)) |->
      ($past(refSample[REF_W-1], 2) ? (level <= 3'sd0) : (level >= 3'sd0)));

endmodule

bind mlpwm_gate_top mlpwm_gate_chk #(.REF_W(REF_W), .CAR_W(CAR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .refSample   (refSample),
  .carrierPeak (carrierPeak),
  .carrierNow  (carrierNow),
  .gates       (gates),
  .level       (level)
);

// File: tb/mlpwm_gate_top_bench.sv
`timescale 1ns/1ps
module mlpwm_gate_top_bench;

  localparam int REF_W = 12;
  localparam int CAR_W = 10;

  typedef struct {
    logic [6:0] gates;
    int         lvl;
    string      tag;
  } expItem_t;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic signed [REF_W-1:0] refSample = '0;
  logic        [CAR_W-1:0] carrierPeak = '0;
  logic        [6:0]       gates;
  logic signed [2:0]       level;

  int checks = 0;
  int fails  = 0;
  bit trackOn = 1'b0;
  bit finished = 1'b0;
  expItem_t sb[$];

  // Bench carrier model (R2, R7)
  int  modelTri = 0;
  bit  modelDown = 1'b0;
  string segTag = "R2";

  always #5 clk = ~clk;

  mlpwm_gate_top #(.REF_W(REF_W), .CAR_W(CAR_W)) u_mlpwm_gate_top (
    .clk(clk), .rstN(rstN), .refSample(refSample),
    .carrierPeak(carrierPeak), .gates(gates), .level(level)
  );

  function automatic logic [6:0] patternFor(int lv);
    case (lv)
      0:  return 7'h28;
      1:  return 7'h1C;
      2:  return 7'h13;
      3:  return 7'h1A;
      -1: return 7'h21;
      -2: return 7'h54;
      default: return 7'h60;
    endcase
  endfunction

  task automatic advanceModel();
    int p;
    p = int'(carrierPeak);
    if (p == 0) begin
      modelTri = 0; modelDown = 1'b0;
    end else if (!modelDown) begin
      if (modelTri >= p) begin modelTri--; modelDown = 1'b1; end
      else modelTri++;
    end else begin
      if (modelTri == 0) begin modelTri = 1; modelDown = 1'b0; end
      else modelTri--;
    end
  endtask

  // Driver: one call per clock, pushes the expected result (R3, R4, R5)
  task automatic drive(int v);
    expItem_t it;
    int m, n, p;
    @(negedge clk);
    refSample = REF_W'(v);
    p = int'(carrierPeak);
    m = (v < 0) ? -v : v;
    n = int'(m >= modelTri) + int'(m >= modelTri + p) + int'(m >= modelTri + 2*p);
    it.lvl   = (v >= 0) ? n : -n;
    it.gates = patternFor(it.lvl);
    it.tag   = segTag;
    sb.push_back(it);
    advanceModel();
  endtask

  // Monitor: result of a sample appears two edges after it is applied (R6)
  always @(posedge clk) begin
    #2;
    if (trackOn && sb.size() >= 2) begin
      expItem_t e;
      e = sb.pop_front();
      checks++;
      if (gates !== e.gates) begin
        fails++;
        $display("FAIL %s R4 R6 gates actual=%h expected=%h", e.tag, gates, e.gates);
      end
      checks++;
      if (int'(level) != e.lvl) begin
        fails++;
        $display("FAIL %s R3 R5 R6 level actual=%0d expected=%0d", e.tag, level, e.lvl);
      end
    end
  end

  // R1: reset state check
  task automatic doReset(int peak);
    trackOn = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    carrierPeak = CAR_W'(peak);
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (gates !== 7'h00 || level !== 3'sd0) begin
      fails++;
      $display("FAIL R1 reset gates=%h level=%0d expected gates=00 level=0", gates, level);
    end
    rstN = 1'b1;
    sb.delete();
    modelTri = 0;
    modelDown = 1'b0;
    trackOn = 1'b1;
  endtask

  initial begin
    // R2 R3: small peak, slow sweep so band edges meet carrier turnarounds
    segTag = "R2";
    doReset(4);
    for (int v = -14; v <= 14; v++) repeat (3) drive(v);

    // R3 R4: larger peak, faster ramp up and down
    segTag = "R3";
    doReset(100);
    for (int v = -310; v <= 310; v += 7) drive(v);
    for (int v = 310; v >= -310; v -= 11) drive(v);

    // R7: zero peak
    segTag = "R7";
    doReset(0);
    drive(0); drive(-1); drive(5); drive(-700); drive(1); drive(0); drive(-3);

    // R8: full-scale codes with the largest peak
    segTag = "R8";
    doReset(1023);
    for (int k = 0; k < 40; k++) begin
      drive(-2048); drive(2047); drive(0); drive(-1);
    end
    doReset(5);
    for (int k = 0; k < 20; k++) begin
      drive(-2048); drive(2047);
    end
    drive(0); drive(0);
    @(posedge clk); #3;
    trackOn = 1'b0;
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule